// File: doc/BRIEF.md
# Eight-bit ALU with per-operation flag update

This block is the arithmetic and logic datapath of a small RISC core. It takes two byte operands, a carry input, a four-bit operation code and the core's current status byte. It returns the byte result and the next status byte. Each operation writes only its own group of flags. All other status bits are copied through unchanged, so the core can write the returned status byte back as it is.

The unit covers:
- addition and subtraction, each with or without the carry input;
- the three bitwise logic operations;
- one's and two's complement;
- increment and decrement;
- logical shift right, arithmetic shift right and rotate right through carry;
- nibble swap.

The combinational datapath sits behind a single register stage, so each operation returns its result and status one clock after it is presented. Register-file access, decoding and word-wide arithmetic belong to other blocks.

Top module: `alu8_core`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBC=3, AND=4, OR=5, XOR=6, COM=7, NEG=8, INC=9, DEC=10, LSR=11, ROR=12, ASR=13, SWAP=14. The status byte, from bit 7 down to bit 0, holds I, T, H, S, V, N, Z, C. Code 15 returns result 0x00 and passes the status byte through unchanged.
- R2: ADD returns a+b and ADC returns a+b+carry_in. Both write C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), N (result bit 7) and Z (result is zero).
- R3: SUB returns a-b, SBC returns a-b-carry_in and NEG returns 0x00-a. C is the borrow out of bit 7, H is the borrow out of bit 3, and V is signed overflow. Z and N are also written.
- R4: For SBC, Z is cleared when the result is nonzero. When the result is zero, Z keeps its previous value.
- R5: AND, OR and XOR write Z and N and clear V. C and H stay unchanged.
- R6: COM returns 0xFF-a, sets C to 1, clears V and writes Z and N. H stays unchanged.
- R7: INC returns a+1 and DEC returns a-1. Both write Z and N. V is set only when INC is given 0x7F or DEC is given 0x80. C and H stay unchanged.
- R8: Each shift puts operand bit 0 into C. The new bit 7 is 0 for LSR, carry_in for ROR, and the old bit 7 for ASR. V is N XOR C, Z and N are written, and H stays unchanged.
- R9: SWAP exchanges bits 7..4 with bits 3..0 and changes no status bit.
- R10: Every operation that writes N or V also writes S as N XOR V. No operation changes I or T.
- R11: Result and status appear one clock after the inputs. While synchronous reset is high, both read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code (R1) |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| cin_i | input | 1 | Carry input for ADC, SBC and ROR |
| sreg_i | input | 8 | Current status byte |
| res_o | output | 8 | Registered result |
| sreg_o | output | 8 | Registered next status byte |

## Verification
The assertions check on every cycle the rules that span all inputs. S always equals N XOR V after any flag-writing operation. I and T are always copied. SWAP and the unused code leave the whole status byte alone. The logic, increment and decrement groups keep their protected flags, and a zero result of SBC never sets Z. Arithmetic values cannot be checked that way. Correct sums, borrows, half-carries and overflow at the 0x7F/0x80 boundaries show only in the bench's scenarios, which compare each result against a separately written model. Those scenarios also cover SBC chains that depend on an earlier Z, and the reset value.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW = 8;
    localparam int SW = 8;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_COM  = 4'd7,
        OP_NEG  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_LSR  = 4'd11,
        OP_ROR  = 4'd12,
        OP_ASR  = 4'd13,
        OP_SWAP = 4'd14,
        OP_NONE = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;

    // Which status bits an operation may write (1 = written).
    function automatic logic [SW-1:0] flag_mask(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: return 8'b0011_1111;
            OP_AND, OP_OR, OP_XOR:                  return 8'b0001_1110;
            OP_INC, OP_DEC:                         return 8'b0001_1110;
            OP_COM, OP_LSR, OP_ROR, OP_ASR:         return 8'b0001_1111;
            default:                                return 8'b0000_0000;
        endcase
    endfunction

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBC) || (op == OP_NEG) || (op == OP_INC) ||
               (op == OP_DEC);
    endfunction

    function automatic logic is_shift(alu_op_e op);
        return (op == OP_LSR) || (op == OP_ROR) || (op == OP_ASR);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = alu8_pkg::DW
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         hout,
    output logic         vout
);
    localparam int HW = W / 2;

    logic [W:0]  full;
    logic [HW:0] half;

    always_comb begin
        if (sub) begin
            full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, ci};
            half = {1'b0, x[HW-1:0]} - {1'b0, y[HW-1:0]} - {{HW{1'b0}}, ci};
        end else begin
            full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
            half = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]} + {{HW{1'b0}}, ci};
        end
        res  = full[W-1:0];
        cout = full[W];
        hout = half[HW];
        if (sub)
            vout = (x[W-1] != y[W-1]) && (full[W-1] != x[W-1]);
        else
            vout = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = alu8_pkg::DW
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int HW = W / 2;

    logic fill;

    always_comb begin
        case (op)
            OP_ROR:  fill = ci;
            OP_ASR:  fill = a[W-1];
            default: fill = 1'b0;
        endcase

        cout = 1'b0;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  begin res = ~a; cout = 1'b1; end
            OP_LSR, OP_ROR, OP_ASR: begin
                res  = {fill, a[W-1:1]};
                cout = a[0];
            end
            OP_SWAP: res = {a[HW-1:0], a[W-1:HW]};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alu8_flagmerge.sv
module alu8_flagmerge
    import alu8_pkg::*;
(
    input  sreg_t          prev,
    input  sreg_t          fresh,
    input  logic [SW-1:0]  mask,
    output sreg_t          merged
);
    always_comb begin
        merged = sreg_t'((prev & ~mask) | (fresh & mask));
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = alu8_pkg::DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic [SW-1:0] sreg_i,
    output logic [W-1:0] res_o,
    output logic [SW-1:0] sreg_o
);
    localparam logic [W-1:0] ONE = W'(1);

    alu_op_e      op;
    sreg_t        prev;
    logic [W-1:0] ax, ay, ar, br, res_d;
    logic         aci, asub, ac, ah, av, bc;
    sreg_t        fresh, merged;

    assign op   = alu_op_e'(op_i);
    assign prev = sreg_t'(sreg_i);

    // Operand routing into the shared adder/subtractor
    always_comb begin
        ax   = a_i;
        ay   = b_i;
        aci  = 1'b0;
        asub = 1'b0;
        case (op)
            OP_ADC: aci = cin_i;
            OP_SUB: asub = 1'b1;
            OP_SBC: begin asub = 1'b1; aci = cin_i; end
            OP_NEG: begin asub = 1'b1; ax = '0; ay = a_i; end
            OP_INC: ay = ONE;
            OP_DEC: begin asub = 1'b1; ay = ONE; end
            default: ;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .x(ax), .y(ay), .ci(aci), .sub(asub),
        .res(ar), .cout(ac), .hout(ah), .vout(av)
    );

    alu8_bitops #(.W(W)) u_bitops (
        .op(op), .a(a_i), .b(b_i), .ci(cin_i),
        .res(br), .cout(bc)
    );

    // Candidate flag values; the mask decides which are kept
    always_comb begin
        res_d   = is_arith(op) ? ar : br;
        fresh   = '0;
        fresh.n = res_d[W-1];
        fresh.z = (res_d == '0) && ((op != OP_SBC) || prev.z);
        fresh.h = ah;
        if (is_arith(op)) begin
            fresh.c = ac;
            fresh.v = av;
        end else if (is_shift(op)) begin
            fresh.c = bc;
            fresh.v = res_d[W-1] ^ bc;
        end else begin
            fresh.c = bc;
            fresh.v = 1'b0;
        end
        fresh.s = fresh.n ^ fresh.v;
    end

    alu8_flagmerge u_merge (
        .prev(prev), .fresh(fresh), .mask(flag_mask(op)), .merged(merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o  <= '0;
            sreg_o <= '0;
        end else begin
            res_o  <= res_d;
            sreg_o <= merged;
        end
    end

    // Assertions
    AST_IT_HELD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sreg_o[7:6] == $past(sreg_i[7:6]));                       // R10
    AST_S_IS_NXV: assert property (@(posedge clk) disable iff (rst)
        (flag_mask(alu_op_e'(op_i)) != '0) |=> sreg_o[4] == (sreg_o[2] ^ sreg_o[3])); // R10
    AST_SWAP_NOFLAG: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd14) |=> sreg_o == $past(sreg_i));                       // R9
    AST_UNUSED_PASS: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd15) |=> (sreg_o == $past(sreg_i)) && (res_o == '0));    // R1
    AST_LOGIC_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op_i inside {4'd4, 4'd5, 4'd6}) |=>
            (sreg_o[0] == $past(sreg_i[0])) && (sreg_o[5] == $past(sreg_i[5])) && !sreg_o[3]); // R5
    AST_INCDEC_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op_i inside {4'd9, 4'd10}) |=>
            (sreg_o[0] == $past(sreg_i[0])) && (sreg_o[5] == $past(sreg_i[5]))); // R7
    AST_SBC_ZSTICKY: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd3 && !sreg_i[1]) |=> !sreg_o[1]);                       // R4
    AST_COM_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd7) |=> sreg_o[0] && !sreg_o[3]);                        // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (res_o == '0) && (sreg_o == '0));                           // R11

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_i = '0;
    logic [7:0] a_i = '0, b_i = '0, sreg_i = '0;
    logic       cin_i = 1'b0;
    logic [7:0] res_o, sreg_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .cin_i(cin_i), .sreg_i(sreg_i), .res_o(res_o), .sreg_o(sreg_o)
    );

    // Independent model: returns {result, status}
    function automatic logic [15:0] model(input int op, input int a, input int b,
                                          input int ci, input int sr);
        int r = 0, c = 0, h = 0, v = 0, n, z, s, mask = 0, x, y, k, d, fresh, nsr;
        case (op)
            0, 1: begin
                k = (op == 1) ? ci : 0;
                d = a + b + k; r = d & 255; c = (d > 255);
                h = ((a & 15) + (b & 15) + k) > 15;
                v = (((a ^ r) & (b ^ r) & 128) != 0); mask = 'h3F;
            end
            2, 3, 8: begin
                x = (op == 8) ? 0 : a; y = (op == 8) ? a : b;
                k = (op == 3) ? ci : 0;
                d = x - y - k; r = d & 255; c = (d < 0);
                h = ((x & 15) - (y & 15) - k) < 0;
                v = (((x ^ y) & (x ^ r) & 128) != 0); mask = 'h3F;
            end
            4: begin r = a & b; mask = 'h1E; end
            5: begin r = a | b; mask = 'h1E; end
            6: begin r = a ^ b; mask = 'h1E; end
            7: begin r = 255 - a; c = 1; mask = 'h1F; end
            9: begin r = (a + 1) & 255; v = (a == 127); mask = 'h1E; end
            10: begin r = (a + 255) & 255; v = (a == 128); mask = 'h1E; end
            11: begin r = a >> 1; c = a & 1; mask = 'h1F; end
            12: begin r = (a >> 1) | (ci << 7); c = a & 1; mask = 'h1F; end
            13: begin r = (a >> 1) | (a & 128); c = a & 1; mask = 'h1F; end
            14: begin r = ((a & 15) << 4) | (a >> 4); mask = 0; end
            default: begin r = 0; mask = 0; end
        endcase
        n = (r >> 7) & 1;
        z = (r == 0) ? 1 : 0;
        if (op == 3) z = z & ((sr >> 1) & 1);
        if (op >= 11 && op <= 13) v = n ^ c;
        s = n ^ v;
        fresh = (h << 5) | (s << 4) | (v << 3) | (n << 2) | (z << 1) | c;
        nsr = (sr & ~mask & 255) | (fresh & mask);
        return {8'(r), 8'(nsr)};
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0, 1:      return "R2";
            2, 8:      return "R3";
            3:         return "R4";
            4, 5, 6:   return "R5";
            7:         return "R6";
            9, 10:     return "R7";
            11, 12, 13: return "R8";
            14:        return "R9";
            default:   return "R1";
        endcase
    endfunction

    task automatic chk(input int op, input int a, input int b, input int ci,
                       input int sr, input string tag);
        logic [15:0] exp;
        @(negedge clk);
        op_i = 4'(op); a_i = 8'(a); b_i = 8'(b); cin_i = 1'(ci); sreg_i = 8'(sr);
        exp = model(op, a, b, ci, sr);
        @(posedge clk); #1;
        total++;
        if ({res_o, sreg_o} !== exp) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h ci=%0d sr=%h: actual res=%h sreg=%h expected res=%h sreg=%h",
                     tag, op, a, b, ci, sr, res_o, sreg_o, exp[15:8], exp[7:0]);
        end
    endtask

    initial begin : watchdog
        #4000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (res_o !== 8'h00 || sreg_o !== 8'h00) begin
            bad++;
            $display("FAIL R11 reset: actual res=%h sreg=%h expected 00 00", res_o, sreg_o);
        end
        @(negedge clk); rst = 1'b0;

        // Directed corner cases
        chk(0, 8'h7F, 8'h01, 0, 8'h00, "R2 overflow");
        chk(0, 8'hFF, 8'h01, 0, 8'h00, "R2 carry zero");
        chk(1, 8'h0F, 8'h00, 1, 8'h00, "R2 half carry");
        chk(2, 8'h80, 8'h01, 0, 8'h00, "R3 overflow");
        chk(2, 8'h00, 8'h01, 0, 8'h00, "R3 borrow");
        chk(8, 8'h80, 8'h00, 0, 8'h00, "R3 neg 0x80");
        chk(8, 8'h00, 8'h00, 0, 8'h3F, "R3 neg zero");
        chk(3, 8'h10, 8'h10, 0, 8'h00, "R4 zero kept clear");
        chk(3, 8'h10, 8'h10, 0, 8'h02, "R4 zero kept set");
        chk(3, 8'h10, 8'h0F, 1, 8'h02, "R4 zero result with carry");
        chk(3, 8'h11, 8'h10, 0, 8'h02, "R4 nonzero clears");
        chk(4, 8'hF0, 8'h0F, 0, 8'h29, "R5 and keeps C H");
        chk(7, 8'hFF, 8'h00, 0, 8'h08, "R6 com zero");
        chk(9, 8'h7F, 8'h00, 0, 8'h21, "R7 inc 0x7F");
        chk(10, 8'h80, 8'h00, 0, 8'h01, "R7 dec 0x80");
        chk(9, 8'hFF, 8'h00, 0, 8'h00, "R7 inc wrap no carry");
        chk(11, 8'h01, 8'h00, 1, 8'h20, "R8 lsr");
        chk(12, 8'h02, 8'h00, 1, 8'h00, "R8 ror fill");
        chk(13, 8'h81, 8'h00, 0, 8'h00, "R8 asr");
        chk(14, 8'hA5, 8'h00, 1, 8'h5A, "R9 swap");
        chk(15, 8'h12, 8'h34, 1, 8'h9C, "R1 unused code");
        chk(0, 8'h40, 8'h40, 0, 8'hC0, "R10 I T kept, S");
        chk(6, 8'h80, 8'h00, 0, 8'h48, "R10 S from N");

        // Constrained random
        for (int i = 0; i < 1500; i++) begin
            int op;
            op = int'($urandom_range(0, 15));
            chk(op, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                int'($urandom_range(0, 1)), int'($urandom_range(0, 255)), req_of(op));
        end

        // R11: reset again returns zeros
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        total++;
        if (res_o !== 8'h00 || sreg_o !== 8'h00) begin
            bad++;
            $display("FAIL R11 re-reset: actual res=%h sreg=%h expected 00 00", res_o, sreg_o);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule